// File: doc/BRIEF.md
# Auxiliary Status Channel with Width Select and Held Change Flag

This block terminates the second status channel of a framed serial link. Once per frame the link delivers a received code word and takes a code word to send back. The code word is 4 or 6 bits wide, and a host-written control bit selects the width. The transmit word is whatever the host last wrote, sent every frame. In 4-bit mode the two upper transmit bits are forced to ones. A received word is checked against the word of the previous frame. Any difference in the bits that count for the selected width raises a change flag in that same frame. There is no two-frame confirmation.

The host can mask the change flag with an enable bit. A change detected while the mask is active is kept pending and shows up as soon as the enable is set again. The change flag is reported in a two-bit status word together with the change flag of the first status channel, which this block receives as an event pulse. A read strobe on that status word clears every flag the host can see. An interrupt line is the OR of the two visible flags. Bus framing and slot arbitration belong to the surrounding logic.

The receive tracker is a three-state machine. TRK_NOREF means no reference word has been captured since reset. TRK_QUIET means a reference is held and no change is pending. TRK_HELD means a change is pending. The transitions are as follows:
- "first frame" moves TRK_NOREF to TRK_QUIET and loads the reference without flagging.
- "change seen" moves TRK_QUIET to TRK_HELD on a frame whose counted bits differ from the previous word.
- "flag read" moves TRK_HELD back to TRK_QUIET on a status read while enabled, unless a new change arrives in the same cycle.

Top module: `aux_status_chan`

## Requirements
- R1: After reset the width is 4 bits, the enable is set, the transmit word is 6'h3F, both status bits (bit 1 = second channel change, bit 0 = first channel change) are 0 and the interrupt is 0.
- R2: With `cfg_wide_in`=1, a `cfg_wr` strobe makes `tx_code` equal to `cfg_tx_in` from the next cycle on.
- R3: With the 4-bit width selected, `tx_code[5:4]` is 2'b11 and `tx_code[3:0]` is the written value's lower 4 bits, whatever was written to the upper two.
- R4: On every `frame_tick`, `rx_code` takes the value of `rx_in` in the next cycle, whatever the enable and width.
- R5: The first `frame_tick` after reset loads the reference and does not raise status bit 1.
- R6: In 4-bit mode, a frame whose `rx_in[3:0]` differs from the previous received word's lower bits sets status bit 1 in the next cycle (enable set), and a difference only in bits 5:4 sets nothing.
- R7: In 6-bit mode, a difference in any of the 6 bits sets status bit 1 in the next cycle (enable set).
- R8: While the enable is 0, status bit 1 reads 0. A change detected during that time stays pending and shows on status bit 1 in the cycle after the enable is written back to 1.
- R9: A `stat_rd` strobe clears both visible status bits in the next cycle. A pending change that is masked is not cleared by it.
- R10: When a set event (a detected change or `ch0_evt`) and `stat_rd` occur in the same cycle, the corresponding status bit is 1 afterwards.
- R11: `irq` equals the OR of the two status bits at all times.
- R12: A `ch0_evt` pulse sets status bit 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_tick | input | 1 | One-cycle strobe marking a frame's received word on `rx_in` |
| rx_in | input | 6 | Received code word of the current frame |
| tx_code | output | 6 | Code word sent in every frame |
| rx_code | output | 6 | Last received code word |
| cfg_wr | input | 1 | Host write strobe for the control fields |
| cfg_wide_in | input | 1 | Width select written by the host: 1 = 6 bits, 0 = 4 bits |
| cfg_en_in | input | 1 | Change flag enable written by the host |
| cfg_tx_in | input | 6 | Transmit word written by the host |
| ch0_evt | input | 1 | Change event pulse from the first status channel |
| stat_rd | input | 1 | Status read strobe; clears the visible flags |
| stat_flags | output | 2 | Bit 1: second channel change; bit 0: first channel change |
| irq | output | 1 | Interrupt request |

## Verification
Every stored result is due one clock after the input that causes it. This covers the received word, the pending change, the first-channel flag, the control fields and the transmit word. The status bits and the interrupt are decoded from those registers without further delay. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge. It compares every output with the model on the next falling edge, so each result is checked exactly one edge after its cause. Directed scenarios then check the boundaries with fixed expected values: the reference frame after reset, changes only in the upper bits in 4-bit mode, a read while masked, and set and clear in the same cycle.

// File: rtl/auxci_pkg.sv
package auxci_pkg;

    typedef enum logic [1:0] {
        TRK_NOREF = 2'd0,
        TRK_QUIET = 2'd1,
        TRK_HELD  = 2'd2
    } trk_state_t;

endpackage

// File: rtl/auxci_cfg.sv
module auxci_cfg #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              wide_i,
    input  logic              en_i,
    input  logic [CODE_W-1:0] tx_i,
    output logic              wide_o,
    output logic              en_o,
    output logic [CODE_W-1:0] tx_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_o <= 1'b0;
            en_o   <= 1'b1;
            tx_o   <= '1;
        end else if (wr_i) begin
            wide_o <= wide_i;
            en_o   <= en_i;
            tx_o   <= tx_i;
        end
    end

endmodule

// File: rtl/auxci_tx_shape.sv
module auxci_tx_shape #(
    parameter int CODE_W   = 6,
    parameter int NARROW_W = 4
) (
    input  logic              wide_i,
    input  logic [CODE_W-1:0] word_i,
    output logic [CODE_W-1:0] code_o
);

    for (genvar b = 0; b < CODE_W; b++) begin : g_bit
        if (b < NARROW_W) begin : g_low
            assign code_o[b] = word_i[b];
        end else begin : g_high
            assign code_o[b] = wide_i ? word_i[b] : 1'b1;
        end
    end

endmodule

// File: rtl/auxci_rx_track.sv
module auxci_rx_track
    import auxci_pkg::*;
#(
    parameter int CODE_W   = 6,
    parameter int NARROW_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic [CODE_W-1:0] rx_i,
    input  logic              wide_i,
    input  logic              clr_i,
    output logic [CODE_W-1:0] rx_q,
    output logic              pend_o
);

    localparam int PAD_W = CODE_W - NARROW_W;
    localparam logic [CODE_W-1:0] MASK_N = {{PAD_W{1'b0}}, {NARROW_W{1'b1}}};

    trk_state_t        state_q;
    trk_state_t        state_d;
    logic [CODE_W-1:0] cmp_mask;
    logic              chg;

    assign cmp_mask = wide_i ? {CODE_W{1'b1}} : MASK_N;
    assign chg      = frame_i && (|((rx_q ^ rx_i) & cmp_mask));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '1;
        end else if (frame_i) begin
            rx_q <= rx_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_NOREF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_NOREF: if (frame_i)          state_d = TRK_QUIET;
            TRK_QUIET: if (chg)              state_d = TRK_HELD;
            TRK_HELD:  if (clr_i && !chg)    state_d = TRK_QUIET;
            default:                         state_d = TRK_NOREF;
        endcase
    end

    always_comb begin
        unique case (state_q)
            TRK_HELD: pend_o = 1'b1;
            default:  pend_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/aux_status_chan.sv
module aux_status_chan
    import auxci_pkg::*;
#(
    parameter int CODE_W   = 6,
    parameter int NARROW_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic [CODE_W-1:0] rx_in,
    output logic [CODE_W-1:0] tx_code,
    output logic [CODE_W-1:0] rx_code,
    input  logic              cfg_wr,
    input  logic              cfg_wide_in,
    input  logic              cfg_en_in,
    input  logic [CODE_W-1:0] cfg_tx_in,
    input  logic              ch0_evt,
    input  logic              stat_rd,
    output logic [1:0]        stat_flags,
    output logic              irq
);

    logic              cfg_wide;
    logic              cfg_en;
    logic [CODE_W-1:0] cfg_tx;
    logic              pend;
    logic              ch0_flag;

    auxci_cfg #(.CODE_W(CODE_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (cfg_wr),
        .wide_i (cfg_wide_in),
        .en_i   (cfg_en_in),
        .tx_i   (cfg_tx_in),
        .wide_o (cfg_wide),
        .en_o   (cfg_en),
        .tx_o   (cfg_tx)
    );

    auxci_tx_shape #(.CODE_W(CODE_W), .NARROW_W(NARROW_W)) u_tx (
        .wide_i (cfg_wide),
        .word_i (cfg_tx),
        .code_o (tx_code)
    );

    auxci_rx_track #(.CODE_W(CODE_W), .NARROW_W(NARROW_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_i (frame_tick),
        .rx_i    (rx_in),
        .wide_i  (cfg_wide),
        .clr_i   (stat_rd && cfg_en),
        .rx_q    (rx_code),
        .pend_o  (pend)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch0_flag <= 1'b0;
        end else if (ch0_evt) begin
            ch0_flag <= 1'b1;
        end else if (stat_rd) begin
            ch0_flag <= 1'b0;
        end
    end

    assign stat_flags = {pend && cfg_en, ch0_flag};
    assign irq        = |stat_flags;

endmodule

// File: rtl/aux_status_chan_chk.sv
module aux_status_chan_chk #(
    parameter int CODE_W   = 6,
    parameter int NARROW_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_tick,
    input logic [CODE_W-1:0] rx_in,
    input logic [CODE_W-1:0] rx_code,
    input logic [CODE_W-1:0] tx_code,
    input logic              cfg_wide,
    input logic              cfg_en,
    input logic              cfg_wr,
    input logic              ch0_evt,
    input logic              stat_rd,
    input logic [1:0]        stat_flags,
    input logic              irq
);

    logic seen_ref;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          seen_ref <= 1'b0;
        else if (frame_tick) seen_ref <= 1'b1;
    end

    // R3
    narrow_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wide |-> (&tx_code[CODE_W-1:NARROW_W]));

    // R4
    rx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> (rx_code == $past(rx_in)));

    // R6
    narrow_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && seen_ref && !cfg_wide && cfg_en && !cfg_wr &&
         (rx_in[NARROW_W-1:0] != rx_code[NARROW_W-1:0])) |=> stat_flags[1]);

    // R8
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !stat_flags[1]);

    // R12
    ch0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch0_evt |=> stat_flags[0]);

    // R9
    ch0_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ch0_evt) |=> !stat_flags[0]);

    // R11
    irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (stat_flags[1] || stat_flags[0]));

endmodule

bind aux_status_chan aux_status_chan_chk #(.CODE_W(CODE_W), .NARROW_W(NARROW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .rx_in      (rx_in),
    .rx_code    (rx_code),
    .tx_code    (tx_code),
    .cfg_wide   (cfg_wide),
    .cfg_en     (cfg_en),
    .cfg_wr     (cfg_wr),
    .ch0_evt    (ch0_evt),
    .stat_rd    (stat_rd),
    .stat_flags (stat_flags),
    .irq        (irq)
);

// File: tb/test_aux_status_chan.sv
`timescale 1ns/1ps
module test_aux_status_chan;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_tick = 1'b0;
    logic [5:0] rx_in = '0;
    logic [5:0] tx_code;
    logic [5:0] rx_code;
    logic       cfg_wr = 1'b0;
    logic       cfg_wide_in = 1'b0;
    logic       cfg_en_in = 1'b1;
    logic [5:0] cfg_tx_in = '0;
    logic       ch0_evt = 1'b0;
    logic       stat_rd = 1'b0;
    logic [1:0] stat_flags;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    aux_status_chan i_aux_status_chan (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .rx_in(rx_in),
        .tx_code(tx_code), .rx_code(rx_code), .cfg_wr(cfg_wr),
        .cfg_wide_in(cfg_wide_in), .cfg_en_in(cfg_en_in), .cfg_tx_in(cfg_tx_in),
        .ch0_evt(ch0_evt), .stat_rd(stat_rd), .stat_flags(stat_flags), .irq(irq)
    );

    // behavioural reference model
    bit   m_wide, m_en, m_ref, m_pend, m_c0;
    int   m_tx, m_rx;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wide = 0; m_en = 1; m_tx = 63; m_rx = 63;
            m_ref = 0; m_pend = 0; m_c0 = 0;
        end else begin
            int  keep;
            bit  set1;
            keep = m_wide ? 63 : 15;
            set1 = frame_tick && m_ref && (((m_rx ^ int'(rx_in)) & keep) != 0);
            if (set1) m_pend = 1;
            else if (stat_rd && m_en) m_pend = 0;
            if (ch0_evt) m_c0 = 1;
            else if (stat_rd) m_c0 = 0;
            if (frame_tick) begin m_rx = int'(rx_in); m_ref = 1; end
            if (cfg_wr) begin
                m_wide = cfg_wide_in; m_en = cfg_en_in; m_tx = int'(cfg_tx_in);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        int etx;
        etx = m_wide ? m_tx : (48 | (m_tx & 15));
        chk(m_wide ? "R2 tx_code" : "R3 tx_code", int'(tx_code), etx);
        chk("R4 rx_code", int'(rx_code), m_rx);
        chk(m_en ? "R6 stat_flags[1]" : "R8 stat_flags[1]", int'(stat_flags[1]), int'(m_pend && m_en));
        chk("R12 stat_flags[0]", int'(stat_flags[0]), int'(m_c0));
        chk("R11 irq", int'(irq), int'((m_pend && m_en) || m_c0));
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare_model();
        frame_tick = 0; cfg_wr = 0; ch0_evt = 0; stat_rd = 0;
    endtask

    task automatic frame(input logic [5:0] v);
        frame_tick = 1; rx_in = v; cyc();
    endtask

    task automatic cfg(input bit w, input bit e, input logic [5:0] t);
        cfg_wr = 1; cfg_wide_in = w; cfg_en_in = e; cfg_tx_in = t; cyc();
    endtask

    task automatic rd();
        stat_rd = 1; cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8ns * 150000);
        errors++;
        $display("FAIL watchdog expired: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_code", int'(tx_code), 63);
        chk("R1 stat_flags", int'(stat_flags), 0);
        chk("R1 irq", int'(irq), 0);

        frame(6'h05);
        chk("R5 first frame no flag", int'(stat_flags[1]), 0);
        chk("R4 rx_code after frame", int'(rx_code), 5);

        frame(6'h35);
        chk("R6 upper bits ignored in narrow", int'(stat_flags[1]), 0);
        frame(6'h36);
        chk("R6 lower change flagged", int'(stat_flags[1]), 1);
        chk("R11 irq on flag", int'(irq), 1);
        rd();
        chk("R9 read clears", int'(stat_flags), 0);

        cfg(1, 1, 6'h0A);
        chk("R2 wide tx", int'(tx_code), 6'h0A);
        cfg(0, 1, 6'h0A);
        chk("R3 narrow tx padded", int'(tx_code), 6'h3A);

        cfg(1, 1, 6'h0A);
        frame(6'h06);
        chk("R7 upper change flagged in wide", int'(stat_flags[1]), 1);
        rd();

        cfg(1, 0, 6'h0A);
        frame(6'h07);
        chk("R8 masked flag hidden", int'(stat_flags[1]), 0);
        chk("R4 rx_code while masked", int'(rx_code), 7);
        rd();
        cfg(1, 1, 6'h0A);
        chk("R8 held change shown", int'(stat_flags[1]), 1);
        chk("R9 masked read kept pending", int'(irq), 1);
        rd();
        chk("R9 cleared after enable", int'(stat_flags[1]), 0);

        frame_tick = 1; rx_in = 6'h00; stat_rd = 1; cyc();
        chk("R10 change beats read", int'(stat_flags[1]), 1);
        ch0_evt = 1; stat_rd = 1; cyc();
        chk("R10 ch0 event beats read", int'(stat_flags[0]), 1);
        rd();
        ch0_evt = 1; cyc();
        chk("R12 ch0 event sets flag", int'(stat_flags), 1);
        rd();

        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom);
            frame_tick = r[0];
            rx_in      = r[9:4];
            stat_rd    = (r[13:11] == 0);
            ch0_evt    = (r[17:15] == 0);
            if (r[21:19] == 0) begin
                cfg_wr = 1; cfg_wide_in = r[22]; cfg_en_in = r[23] | r[24];
                cfg_tx_in = r[30:25];
            end
            cyc();
        end
        finish_run();
    end

endmodule